// File: doc/BRIEF.md
# Tile Memory Window Address Translator

This block turns a 14-bit video-bus address into a 15-bit address for a 32 KiB pattern RAM. The 8 KiB pattern space is handled as 32 rows of 256 bytes, and the RAM holds 128 such rows. Most rows map straight onto the same row of RAM. Two remap windows can send chosen rows elsewhere. The first is a span of consecutive rows of any length. The second is a single row, and it wins over the span when the two overlap. Nametable accesses, where video address bit 13 is set, are steered into a fixed high region of the RAM. In that region one address bit comes from the selected mirroring mode.

A CPU-side write port loads six small configuration registers through a 4-bit index and an 8-bit data byte. The translation is purely combinational from the video address and the registered configuration, so the RAM address follows the video address within the same cycle.

Top module: `tile_window_xlat`

## Requirements
- R1: ram_addr[7:0] always equals vid_addr[7:0].
- R2: For a pattern access (vid_addr[13]=0) that hits no window, ram_addr[14:13]=0 and ram_addr[12:8] equals the row number vid_addr[12:8].
- R3: Span window: offset = (row - span_base) mod 32. If offset <= span_last, ram_addr[14:8] = (span_dest + offset) mod 128, including spans that wrap past row 31 to row 0.
- R4: Single-row window: if row equals one_src, ram_addr[14:8] = one_dst, whether or not the row is also inside the span.
- R5: For a nametable access (vid_addr[13]=1), ram_addr[14:12]=111, ram_addr[11]=vid_addr[11], ram_addr[9:8]=vid_addr[9:8], and vid_addr[12] has no effect.
- R6: In nametable space, ram_addr[10] depends on the mirroring code: 0 gives 0, 1 gives 1, 2 gives vid_addr[10], 3 gives vid_addr[11], 4 (four-screen) gives vid_addr[10], and codes 5 to 7 give 0.
- R7: A write with cfg_we=1 loads the register picked by cfg_idx. Index 0 is span_base (data[4:0]), 1 is span_last (data[4:0]), 2 is span_dest (data[6:0]), 3 is one_src (data[4:0]), 4 is one_dst (data[6:0]), and 5 is the mirroring code (data[2:0]). Higher data bits are dropped, and writes to indices 6 to 15 change nothing.
- R8: A synchronous reset clears every register to 0, which gives an identity mapping for all pattern rows.
- R9: With span_dest = span_base and span_base + span_last <= 31, the span maps every row to itself. With one_dst = one_src, the single-row window maps its row to itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index of the write |
| cfg_data | input | 8 | Write data |
| vid_addr | input | 14 | Video-bus address |
| ram_addr | output | 15 | Pattern RAM address |

## Verification
The bench sweeps all 32 rows under several settings. These include a span that wraps from row 31 to row 0, a single-row window placed inside a span, and settings that make both windows do nothing. A wrong 5-bit subtraction or a compare without wrap would leave the wrapped rows unmapped. A reversed priority would send the overlapped row to the span destination instead of the single-row target. All eight mirroring codes are applied with every mix of address bits 10, 11 and 12, which catches a mirroring bit taken from the wrong source or bit 12 leaking into nametable addresses. Writes to unused indices, and writes with upper data bits set, must leave the mapping unchanged.

// File: rtl/txl_pkg.sv
package txl_pkg;
    parameter int ROW_W  = 5;
    parameter int PAGE_W = 7;
    parameter int LOW_W  = 8;
    localparam int VA_W  = ROW_W + LOW_W + 1;
    localparam int RA_W  = PAGE_W + LOW_W;
    localparam int MIR_W = 3;

    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [PAGE_W-1:0] page_t;

    typedef enum logic [MIR_W-1:0] {
        MIR_ONE_LO = 3'd0,
        MIR_ONE_HI = 3'd1,
        MIR_VERT   = 3'd2,
        MIR_HORIZ  = 3'd3,
        MIR_FOUR   = 3'd4
    } mir_e;

    typedef struct packed {
        row_t              span_base;
        row_t              span_last;
        page_t             span_dest;
        row_t              one_src;
        page_t             one_dst;
        logic [MIR_W-1:0]  mir;
    } cfg_t;

    localparam logic [3:0] P_SPAN_BASE = 4'd0;
    localparam logic [3:0] P_SPAN_LAST = 4'd1;
    localparam logic [3:0] P_SPAN_DEST = 4'd2;
    localparam logic [3:0] P_ONE_SRC   = 4'd3;
    localparam logic [3:0] P_ONE_DST   = 4'd4;
    localparam logic [3:0] P_MIR       = 4'd5;

    // Selects the page bit that splits the nametable region.
    function automatic logic nt_split_bit(input logic [MIR_W-1:0] mode,
                                          input logic a10, input logic a11);
        case (mode)
            MIR_ONE_LO: return 1'b0;
            MIR_ONE_HI: return 1'b1;
            MIR_VERT:   return a10;
            MIR_HORIZ:  return a11;
            MIR_FOUR:   return a10;
            default:    return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/tx_cfg_bank.sv
module tx_cfg_bank
    import txl_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [3:0]   idx,
    input  logic [7:0]   data,
    output cfg_t         cfg
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            case (idx)
                P_SPAN_BASE: cfg_q.span_base <= data[ROW_W-1:0];
                P_SPAN_LAST: cfg_q.span_last <= data[ROW_W-1:0];
                P_SPAN_DEST: cfg_q.span_dest <= data[PAGE_W-1:0];
                P_ONE_SRC:   cfg_q.one_src   <= data[ROW_W-1:0];
                P_ONE_DST:   cfg_q.one_dst   <= data[PAGE_W-1:0];
                P_MIR:       cfg_q.mir       <= data[MIR_W-1:0];
                default:     ;
            endcase
        end
    end

    assign cfg = cfg_q;

    a_r7_base_load: assert property (@(posedge clk) disable iff (rst)
        (we && idx == P_SPAN_BASE) |=> cfg.span_base == $past(data[ROW_W-1:0]));
    a_r7_dest_load: assert property (@(posedge clk) disable iff (rst)
        (we && idx == P_SPAN_DEST) |=> cfg.span_dest == $past(data[PAGE_W-1:0]));
    a_r7_spare_idx: assert property (@(posedge clk) disable iff (rst)
        (we && idx > P_MIR) |=> $stable(cfg));
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg));
endmodule

// File: rtl/tx_row_remap.sv
module tx_row_remap
    import txl_pkg::*;
(
    input  row_t   row,
    input  cfg_t   cfg,
    output page_t  page
);
    row_t  offset;
    logic  in_span;
    logic  one_hit;
    page_t span_page;

    always_comb begin
        offset    = row - cfg.span_base;
        in_span   = (offset <= cfg.span_last);
        span_page = cfg.span_dest + PAGE_W'(offset);
        one_hit   = (row == cfg.one_src);
        if (one_hit)
            page = cfg.one_dst;
        else if (in_span)
            page = span_page;
        else
            page = PAGE_W'(row);
    end
endmodule

// File: rtl/tx_nt_steer.sv
module tx_nt_steer
    import txl_pkg::*;
(
    input  logic [VA_W-1:0]  addr,
    input  logic [MIR_W-1:0] mir,
    output page_t            page
);
    localparam int A10 = LOW_W + 2;
    localparam int A11 = LOW_W + 3;

    always_comb begin
        page = '1;
        page[3] = addr[A11];
        page[2] = nt_split_bit(mir, addr[A10], addr[A11]);
        page[1] = addr[LOW_W+1];
        page[0] = addr[LOW_W];
    end
endmodule

// File: rtl/tile_window_xlat.sv
module tile_window_xlat
    import txl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [3:0]           cfg_idx,
    input  logic [7:0]           cfg_data,
    input  logic [VA_W-1:0]      vid_addr,
    output logic [RA_W-1:0]      ram_addr
);
    localparam int NT_BIT = VA_W - 1;

    cfg_t  cfg;
    page_t pat_page;
    page_t nt_page;
    row_t  row;

    assign row = vid_addr[LOW_W +: ROW_W];

    tx_cfg_bank u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .data(cfg_data), .cfg(cfg)
    );

    tx_row_remap u_rows (.row(row), .cfg(cfg), .page(pat_page));

    tx_nt_steer u_nt (.addr(vid_addr), .mir(cfg.mir), .page(nt_page));

    assign ram_addr = {(vid_addr[NT_BIT] ? nt_page : pat_page), vid_addr[LOW_W-1:0]};

    a_r1_low_pass: assert property (@(posedge clk) disable iff (rst)
        ram_addr[LOW_W-1:0] == vid_addr[LOW_W-1:0]);
    a_r5_nt_region: assert property (@(posedge clk) disable iff (rst)
        vid_addr[NT_BIT] |-> (ram_addr[RA_W-1 -: 3] == 3'b111));
    a_r4_solo_wins: assert property (@(posedge clk) disable iff (rst)
        (!vid_addr[NT_BIT] && row == cfg.one_src) |-> ram_addr[RA_W-1:LOW_W] == cfg.one_dst);
    a_r6_fixed_lo: assert property (@(posedge clk) disable iff (rst)
        (vid_addr[NT_BIT] && cfg.mir == MIR_ONE_LO) |-> !ram_addr[LOW_W+2]);
endmodule

// File: tb/sim_tile_window_xlat.sv
module sim_tile_window_xlat;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [7:0]  cfg_data = '0;
    logic [13:0] vid_addr = '0;
    logic [14:0] ram_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [4:0] m_base, m_last, m_src;
    logic [6:0] m_dest, m_dst;
    logic [2:0] m_mir;

    always #2.5 clk = ~clk;

    tile_window_xlat u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .vid_addr(vid_addr), .ram_addr(ram_addr)
    );

    function automatic logic [14:0] model(input logic [13:0] a);
        logic [4:0] r, off;
        logic [6:0] pg;
        logic b10;
        r = a[12:8];
        if (a[13]) begin
            case (m_mir)
                3'd0: b10 = 1'b0;
                3'd1: b10 = 1'b1;
                3'd2: b10 = a[10];
                3'd3: b10 = a[11];
                3'd4: b10 = a[10];
                default: b10 = 1'b0;
            endcase
            pg = {3'b111, a[11], b10, a[9], a[8]};
        end else begin
            off = r - m_base;
            if (r == m_src) pg = m_dst;
            else if (off <= m_last) pg = m_dest + {2'b00, off};
            else pg = {2'b00, r};
        end
        return {pg, a[7:0]};
    endfunction

    task automatic check(input string tag, input logic [14:0] got, input logic [14:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s vid=%h got=%h exp=%h", tag, vid_addr, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] i, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = i; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (i)
            4'd0: m_base = d[4:0];
            4'd1: m_last = d[4:0];
            4'd2: m_dest = d[6:0];
            4'd3: m_src  = d[4:0];
            4'd4: m_dst  = d[6:0];
            4'd5: m_mir  = d[2:0];
            default: ;
        endcase
    endtask

    task automatic sweep(input string tag, input logic [7:0] lo);
        for (int r = 0; r < 32; r++) begin
            vid_addr = {1'b0, 5'(r), lo ^ 8'(r * 11)};
            #1;
            check(tag, ram_addr, model(vid_addr));
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_base = 0; m_last = 0; m_dest = 0; m_src = 0; m_dst = 0; m_mir = 0;
        for (int r = 0; r < 32; r++) begin
            vid_addr = {1'b0, 5'(r), 8'(r * 7)};
            #1;
            check("R8_R2_R1", ram_addr, {2'b00, 5'(r), 8'(r * 7)});
        end
    endtask

    task automatic t_span();
        wr(4'd0, 8'd4); wr(4'd1, 8'd5); wr(4'd2, 8'h50);
        wr(4'd3, 8'd31); wr(4'd4, 8'd31);
        sweep("R3_span", 8'h3C);
        vid_addr = 14'h0912; #1;
        check("R3_span_row9", ram_addr, 15'h5512);
        vid_addr = 14'h0A12; #1;
        check("R2_after_span", ram_addr, 15'h0A12);
    endtask

    task automatic t_wrap();
        wr(4'd0, 8'd28); wr(4'd1, 8'd6); wr(4'd2, 8'h10);
        sweep("R3_wrap", 8'hA5);
        vid_addr = 14'h0200; #1;
        check("R3_wrap_row2", ram_addr, 15'h1600);
        vid_addr = 14'h0300; #1;
        check("R2_wrap_row3", ram_addr, 15'h0300);
    endtask

    task automatic t_overlap();
        wr(4'd0, 8'd8); wr(4'd1, 8'd7); wr(4'd2, 8'h60);
        wr(4'd3, 8'd10); wr(4'd4, 8'h7F);
        sweep("R4_overlap", 8'h00);
        vid_addr = 14'h0A44; #1;
        check("R4_solo_row10", ram_addr, 15'h7F44);
        vid_addr = 14'h0B44; #1;
        check("R3_span_row11", ram_addr, 15'h6344);
    endtask

    task automatic t_disable();
        wr(4'd0, 8'd6); wr(4'd1, 8'd9); wr(4'd2, 8'd6);
        wr(4'd3, 8'd3); wr(4'd4, 8'd3);
        for (int r = 0; r < 32; r++) begin
            vid_addr = {1'b0, 5'(r), 8'h5A};
            #1;
            check("R9_identity", ram_addr, {2'b00, 5'(r), 8'h5A});
        end
    endtask

    task automatic t_nametable();
        for (int m = 0; m < 8; m++) begin
            wr(4'd5, 8'(m) | 8'hF8);
            for (int b = 0; b < 32; b++) begin
                vid_addr = {1'b1, 5'(b), 8'(b * 9 + m)};
                #1;
                check("R5_R6_nt", ram_addr, model(vid_addr));
            end
        end
        wr(4'd5, 8'd3);
        vid_addr = 14'h3B21; #1;
        check("R6_horiz", ram_addr, 15'h7F21);
        vid_addr = 14'h2B21; #1;
        check("R5_a12_ignored", ram_addr, 15'h7F21);
    endtask

    task automatic t_spare_idx();
        wr(4'd0, 8'hE3); wr(4'd1, 8'hE2); wr(4'd2, 8'hC0);
        wr(4'd3, 8'hFF); wr(4'd4, 8'h85);
        vid_addr = 14'h0410; #1;
        check("R7_upper_dropped", ram_addr, 15'h4110);
        for (int i = 6; i < 16; i++) wr(4'(i), 8'hFF);
        sweep("R7_spare_idx", 8'h77);
        vid_addr = 14'h2400; #1;
        check("R7_spare_mir", ram_addr, model(vid_addr));
    endtask

    initial begin
        t_reset();
        t_span();
        t_wrap();
        t_overlap();
        t_disable();
        t_nametable();
        t_spare_idx();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired got=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule